// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a 16-bit timing unit built around a counter that runs freely from reset. Two capture channels record the counter value when their input pins show a selected edge. Two compare channels act on their own output pins when the counter reaches a programmed value. A rollover of the counter is also reported. Software sees everything through an 8-bit register port, so every 16-bit quantity is split into a high byte and a low byte.

The byte split drives the main rule of access. Touching the high byte of a channel, by read or write, freezes that channel. Touching its low byte releases it. So a capture value that is read high-then-low is never torn, and a compare value that is written high-then-low never fires half-updated. Counter reads are made coherent a different way: a high-byte read takes a snapshot of the low byte, and the next low-byte read returns that snapshot.

The register port is a plain strobe interface with no back-pressure. A read is returned combinationally in the same cycle as `reg_rd`, and its side effects take place at the next clock edge. A write takes effect at the clock edge where `reg_wr` is high. `reg_rd` and `reg_wr` are never high together.

Register addresses: 0 counter high, 1 counter low, 2/3 capture 0 high/low, 4/5 capture 1 high/low, 6/7 compare 0 high/low, 8/9 compare 1 high/low, 10 capture config, 11 compare config, 12 flags, 13 interrupt enables. Unmapped addresses read 0.

Top module: `capcmp_timer`

## Requirements
- R1: The counter advances by one, modulo 65536, on every clock (default fixed prescale of 1). Writes to addresses 0 and 1 have no effect on it. A read of address 1 with no pending snapshot returns the live low byte.
- R2: Reading address 0 returns the counter's high byte and stores the counter's low byte from that same cycle. The next read of address 1 returns the stored byte and clears the pending state.
- R3: Address 10 sets the capture edge: bits [1:0] for channel 0 and bits [3:2] for channel 1, with 00 = off, 01 = rising, 10 = falling, 11 = both. Each pin passes through two flops and an edge detector. If the pin changes just before clock edge E0, the latch loads the counter value present at edge E0+2. With a prescale of 1, that value is the counter value seen before E0, plus 2.
- R4: Each capture sets its flag. The flags are at address 12: bit 0 for capture 0 and bit 1 for capture 1.
- R5: An access to a capture channel's high byte freezes that channel. While frozen, qualifying edges change neither the latch nor the flag. An access to the low byte unfreezes the channel.
- R6: A compare channel matches in the cycle where the counter equals its register. At the clock edge where the counter leaves that value, the match sets flag bit 2 (channel 0) or bit 3 (channel 1). This happens whatever the pin action is.
- R7: Address 11 sets each compare pin action: bits [1:0] for channel 0 and bits [3:2] for channel 1, with 00 = none, 01 = toggle, 10 = clear, 11 = set. The pin changes on the same edge as the flag.
- R8: A write to a compare high byte loads that byte and freezes the channel, so it does not match. A write to the low byte loads that byte and unfreezes the channel.
- R9: When the counter wraps from 0xFFFF to 0x0000, flag bit 4 is set.
- R10: Writing 1 to a bit at address 12 clears that flag. If a hardware set falls in the same cycle, the set wins.
- R11: `irq` is high exactly when some flag is set and its enable bit is set at address 13 (same bit layout as the flags).
- R12: After reset, the counter, flags, enables, configs, pins and `irq` are all 0, both compare registers are 0xFFFF, and no channel is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (read side effects at next edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| cap_in | input | 2 | Capture input pins, asynchronous |
| cmp_out | output | 2 | Compare output pins |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones that must land on one exact counter cycle. One is a flag clear that coincides with a compare match. Another is a channel that is frozen while its trigger condition passes. The bench keeps a cycle-exact model of the counter, so it can wait until the model's count is one below the target before it issues the write. It holds a channel frozen across a full pass of its compare value or across a pin edge, and then proves the channel resumes. The overflow case is reached by letting the model count run up to 0xFFFE.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 2 * BYTE_W;
  localparam int NUM_CAP = 2;
  localparam int NUM_CMP = 2;
  localparam int ADDR_W  = 4;
  localparam int FLAG_W  = NUM_CAP + NUM_CMP + 1;

  localparam int CAP_FLAG0 = 0;
  localparam int CMP_FLAG0 = NUM_CAP;
  localparam int OVF_FLAG  = NUM_CAP + NUM_CMP;

  localparam logic [ADDR_W-1:0] A_CNT_HI   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CAP_BASE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMP_BASE = ADDR_W'(2 + 2 * NUM_CAP);
  localparam logic [ADDR_W-1:0] A_CAP_CFG  = ADDR_W'(2 + 2 * NUM_CAP + 2 * NUM_CMP);
  localparam logic [ADDR_W-1:0] A_CMP_CFG  = ADDR_W'(3 + 2 * NUM_CAP + 2 * NUM_CMP);
  localparam logic [ADDR_W-1:0] A_FLAGS    = ADDR_W'(4 + 2 * NUM_CAP + 2 * NUM_CMP);
  localparam logic [ADDR_W-1:0] A_IEN      = ADDR_W'(5 + 2 * NUM_CAP + 2 * NUM_CMP);

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;
endpackage

// File: rtl/capcmp_counter.sv
module capcmp_counter
  import capcmp_pkg::*;
#(
  parameter int PRESCALE = 1,
  parameter int WIDTH    = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic              tick,
  output logic [WIDTH-1:0]  count,
  output logic [BYTE_W-1:0] lo_view
);
  logic [BYTE_W-1:0] snap_q;
  logic              snap_v_q;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(PRESCALE);
      localparam logic [DW-1:0] LAST = DW'(PRESCALE - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      snap_v_q <= 1'b0;
    end else if (rd_hi) begin
      snap_q   <= count[BYTE_W-1:0];
      snap_v_q <= 1'b1;
    end else if (rd_lo) begin
      snap_v_q <= 1'b0;
    end
  end

  assign lo_view = snap_v_q ? snap_q : count[BYTE_W-1:0];
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture
  import capcmp_pkg::*;
#(
  parameter int WIDTH      = CNT_W,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  edge_sel_e        sel,
  input  logic             freeze,
  input  logic             thaw,
  input  logic [WIDTH-1:0] count,
  output logic             event_o,
  output logic [WIDTH-1:0] value,
  output logic             inhibited
);
  logic [SYNC_DEPTH:0] sh_q;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_DEPTH-1:0], pin};
  end

  assign rise = sh_q[SYNC_DEPTH-1] & ~sh_q[SYNC_DEPTH];
  assign fall = ~sh_q[SYNC_DEPTH-1] & sh_q[SYNC_DEPTH];

  always_comb begin
    case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign event_o = hit & ~inhibited;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (event_o) value <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inhibited <= 1'b0;
    else if (freeze) inhibited <= 1'b1;
    else if (thaw)   inhibited <= 1'b0;
  end
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare
  import capcmp_pkg::*;
#(
  parameter int WIDTH = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmp_act_e          act,
  input  logic              freeze,
  input  logic              thaw,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WIDTH-1:0]  count,
  input  logic              tick,
  output logic              match_o,
  output logic              pin_o,
  output logic [WIDTH-1:0]  value,
  output logic              inhibited
);
  assign match_o = tick & ~inhibited & (count == value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '1;
    end else begin
      if (wr_hi) value[WIDTH-1:BYTE_W] <= wdata;
      if (wr_lo) value[BYTE_W-1:0]     <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inhibited <= 1'b0;
    else if (freeze) inhibited <= 1'b1;
    else if (thaw)   inhibited <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o <= 1'b0;
    end else if (match_o) begin
      case (act)
        ACT_TOGGLE: pin_o <= ~pin_o;
        ACT_CLEAR:  pin_o <= 1'b0;
        ACT_SET:    pin_o <= 1'b1;
        default:    pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int PRESCALE   = 1,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic [NUM_CAP-1:0] cap_in,
  output logic [NUM_CMP-1:0] cmp_out,
  output logic               irq
);
  logic                          access;
  logic                          tick_w;
  logic [CNT_W-1:0]              count_w;
  logic [BYTE_W-1:0]             lo_view;
  logic [2*NUM_CAP-1:0]          cap_cfg_q;
  logic [2*NUM_CMP-1:0]          cmp_cfg_q;
  logic [FLAG_W-1:0]             flags_q;
  logic [FLAG_W-1:0]             ien_q;
  logic [FLAG_W-1:0]             flag_set;
  logic [FLAG_W-1:0]             flag_clr;
  logic [NUM_CAP-1:0]            cap_evt;
  logic [NUM_CAP-1:0]            cap_inh;
  logic [NUM_CAP-1:0][CNT_W-1:0] cap_val;
  logic [NUM_CMP-1:0]            cmp_match;
  logic [NUM_CMP-1:0]            cmp_inh;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
  logic                          ovf;

  assign access = reg_wr | reg_rd;

  capcmp_counter #(.PRESCALE(PRESCALE), .WIDTH(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hi   (reg_rd && reg_addr == A_CNT_HI),
    .rd_lo   (reg_rd && reg_addr == A_CNT_LO),
    .tick    (tick_w),
    .count   (count_w),
    .lo_view (lo_view)
  );

  generate
    for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
      localparam logic [ADDR_W-1:0] HI = A_CAP_BASE + ADDR_W'(2 * i);
      localparam logic [ADDR_W-1:0] LO = HI + ADDR_W'(1);
      capcmp_capture #(.WIDTH(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (cap_in[i]),
        .sel       (edge_sel_e'(cap_cfg_q[2*i +: 2])),
        .freeze    (access && reg_addr == HI),
        .thaw      (access && reg_addr == LO),
        .count     (count_w),
        .event_o   (cap_evt[i]),
        .value     (cap_val[i]),
        .inhibited (cap_inh[i])
      );
    end

    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
      localparam logic [ADDR_W-1:0] HI = A_CMP_BASE + ADDR_W'(2 * j);
      localparam logic [ADDR_W-1:0] LO = HI + ADDR_W'(1);
      capcmp_compare #(.WIDTH(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (cmp_act_e'(cmp_cfg_q[2*j +: 2])),
        .freeze    (access && reg_addr == HI),
        .thaw      (access && reg_addr == LO),
        .wr_hi     (reg_wr && reg_addr == HI),
        .wr_lo     (reg_wr && reg_addr == LO),
        .wdata     (reg_wdata),
        .count     (count_w),
        .tick      (tick_w),
        .match_o   (cmp_match[j]),
        .pin_o     (cmp_out[j]),
        .value     (cmp_val[j]),
        .inhibited (cmp_inh[j])
      );
    end
  endgenerate

  assign ovf      = tick_w && (count_w == '1);
  assign flag_set = {ovf, cmp_match, cap_evt};
  assign flag_clr = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cfg_q <= '0;
      cmp_cfg_q <= '0;
      ien_q     <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CAP_CFG) cap_cfg_q <= reg_wdata[2*NUM_CAP-1:0];
      if (reg_addr == A_CMP_CFG) cmp_cfg_q <= reg_wdata[2*NUM_CMP-1:0];
      if (reg_addr == A_IEN)     ien_q     <= reg_wdata[FLAG_W-1:0];
    end
  end

  assign irq = |(flags_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT_HI:  reg_rdata = count_w[CNT_W-1:BYTE_W];
      A_CNT_LO:  reg_rdata = lo_view;
      A_CAP_CFG: reg_rdata = BYTE_W'(cap_cfg_q);
      A_CMP_CFG: reg_rdata = BYTE_W'(cmp_cfg_q);
      A_FLAGS:   reg_rdata = BYTE_W'(flags_q);
      A_IEN:     reg_rdata = BYTE_W'(ien_q);
      default:   reg_rdata = '0;
    endcase
    for (int i = 0; i < NUM_CAP; i++) begin
      if (reg_addr == A_CAP_BASE + ADDR_W'(2 * i))     reg_rdata = cap_val[i][CNT_W-1:BYTE_W];
      if (reg_addr == A_CAP_BASE + ADDR_W'(2 * i + 1)) reg_rdata = cap_val[i][BYTE_W-1:0];
    end
    for (int j = 0; j < NUM_CMP; j++) begin
      if (reg_addr == A_CMP_BASE + ADDR_W'(2 * j))     reg_rdata = cmp_val[j][CNT_W-1:BYTE_W];
      if (reg_addr == A_CMP_BASE + ADDR_W'(2 * j + 1)) reg_rdata = cmp_val[j][BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
  import capcmp_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic [CNT_W-1:0]              count,
  input logic                          tick,
  input logic [FLAG_W-1:0]             flags,
  input logic [FLAG_W-1:0]             ien,
  input logic                          irq,
  input logic [NUM_CAP-1:0]            cap_inh,
  input logic [NUM_CAP-1:0][CNT_W-1:0] cap_val,
  input logic [NUM_CMP-1:0]            cmp_inh,
  input logic [NUM_CMP-1:0]            cmp_out
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + CNT_W'(1)));

  a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '1) |=> flags[OVF_FLAG]);

  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  generate
    for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap_chk
      a_r5_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cap_inh[i] |=> $stable(cap_val[i]));
    end
    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp_chk
      a_r8_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_inh[j] |=> $stable(cmp_out[j]));
    end
  endgenerate
endmodule

bind capcmp_timer capcmp_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .count   (count_w),
  .tick    (tick_w),
  .flags   (flags_q),
  .ien     (ien_q),
  .irq     (irq),
  .cap_inh (cap_inh),
  .cap_val (cap_val),
  .cmp_inh (cmp_inh),
  .cmp_out (cmp_out)
);

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  import capcmp_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic               reg_wr = 1'b0;
  logic               reg_rd = 1'b0;
  logic [BYTE_W-1:0]  reg_wdata = '0;
  logic [BYTE_W-1:0]  reg_rdata;
  logic [NUM_CAP-1:0] cap_in = '0;
  logic [NUM_CMP-1:0] cmp_out;
  logic               irq;

  int n_checks = 0;
  int n_fail = 0;
  bit started = 0;
  int last_rd;

  capcmp_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int m_cnt, m_snap, m_capcfg, m_cmpcfg, m_flags, m_ien;
  bit m_snapv;
  int m_cap[2];
  int m_cmp[2];
  bit m_capinh[2];
  bit m_cmpinh[2];
  bit m_out[2];
  bit m_p1[2], m_p2[2], m_p3[2];

  always @(posedge clk) begin
    int setv, clr, a, sel, act;
    bit acc, r, f, hit;
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_snapv = 0; m_capcfg = 0; m_cmpcfg = 0;
      m_flags = 0; m_ien = 0;
      for (int i = 0; i < 2; i++) begin
        m_cap[i] = 0; m_cmp[i] = 65535; m_capinh[i] = 0; m_cmpinh[i] = 0;
        m_out[i] = 0; m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0;
      end
    end else begin
      setv = 0;
      acc = reg_wr || reg_rd;
      a = int'(reg_addr);
      for (int i = 0; i < 2; i++) begin
        sel = (m_capcfg >> (2 * i)) & 3;
        r = m_p2[i] && !m_p3[i];
        f = !m_p2[i] && m_p3[i];
        hit = (sel == 1 && r) || (sel == 2 && f) || (sel == 3 && (r || f));
        if (hit && !m_capinh[i]) begin
          m_cap[i] = m_cnt;
          setv |= (1 << i);
        end
        if (acc && a == 2 + 2 * i) m_capinh[i] = 1;
        if (acc && a == 3 + 2 * i) m_capinh[i] = 0;
      end
      for (int i = 0; i < 2; i++) begin
        if (!m_cmpinh[i] && m_cnt == m_cmp[i]) begin
          setv |= (1 << (2 + i));
          act = (m_cmpcfg >> (2 * i)) & 3;
          if (act == 1) m_out[i] = !m_out[i];
          else if (act == 2) m_out[i] = 0;
          else if (act == 3) m_out[i] = 1;
        end
        if (reg_wr && a == 6 + 2 * i) m_cmp[i] = (m_cmp[i] & 255) | (int'(reg_wdata) << 8);
        if (reg_wr && a == 7 + 2 * i) m_cmp[i] = (m_cmp[i] & 65280) | int'(reg_wdata);
        if (acc && a == 6 + 2 * i) m_cmpinh[i] = 1;
        if (acc && a == 7 + 2 * i) m_cmpinh[i] = 0;
      end
      if (m_cnt == 65535) setv |= 16;
      clr = (reg_wr && a == 12) ? (int'(reg_wdata) & 31) : 0;
      m_flags = (m_flags & ~clr) | setv;
      if (reg_wr && a == 10) m_capcfg = int'(reg_wdata) & 15;
      if (reg_wr && a == 11) m_cmpcfg = int'(reg_wdata) & 15;
      if (reg_wr && a == 13) m_ien = int'(reg_wdata) & 31;
      if (reg_rd && a == 0) begin
        m_snap = m_cnt & 255; m_snapv = 1;
      end else if (reg_rd && a == 1) begin
        m_snapv = 0;
      end
      m_cnt = (m_cnt + 1) & 65535;
      for (int i = 0; i < 2; i++) begin
        m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; m_p1[i] = cap_in[i];
      end
    end
  end

  function automatic int m_rdata(input int a);
    case (a)
      0: return m_cnt >> 8;
      1: return m_snapv ? m_snap : (m_cnt & 255);
      2: return m_cap[0] >> 8;
      3: return m_cap[0] & 255;
      4: return m_cap[1] >> 8;
      5: return m_cap[1] & 255;
      6: return m_cmp[0] >> 8;
      7: return m_cmp[0] & 255;
      8: return m_cmp[1] >> 8;
      9: return m_cmp[1] & 255;
      10: return m_capcfg;
      11: return m_cmpcfg;
      12: return m_flags;
      13: return m_ien;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of pins and interrupt against the model
  always @(negedge clk) begin
    if (rst_n && started) begin
      #1;
      check("R7 cmp_out[0]", int'(cmp_out[0]), int'(m_out[0]));
      check("R7 cmp_out[1]", int'(cmp_out[1]), int'(m_out[1]));
      check("R11 irq", int'(irq), ((m_flags & m_ien) != 0) ? 1 : 0);
    end
  end

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    reg_addr = ADDR_W'(a); reg_wdata = BYTE_W'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input int a, input string tag);
    @(negedge clk);
    reg_addr = ADDR_W'(a); reg_rd = 1'b1;
    #1;
    last_rd = int'(reg_rdata);
    check(tag, last_rd, m_rdata(a));
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c, v, lo1, lo2, t0, t1;
    idle(4);
    rst_n = 1'b1;
    started = 1;
    idle(2);

    // R12 reset state
    do_read(12, "R12 flags");  check("R12 flags zero", last_rd, 0);
    do_read(13, "R12 ien");    check("R12 ien zero", last_rd, 0);
    do_read(10, "R12 capcfg"); check("R12 capcfg zero", last_rd, 0);
    do_read(6, "R12 cmp0 hi"); check("R12 cmp0 hi FF", last_rd, 255);
    do_read(7, "R12 cmp0 lo"); check("R12 cmp0 lo FF", last_rd, 255);
    check("R12 pins", int'(cmp_out), 0);

    // R1 live counting, writes ignored
    do_read(1, "R1 live lo"); lo1 = last_rd;
    do_read(1, "R1 live lo"); lo2 = last_rd;
    check("R1 step of two", (lo2 - lo1) & 255, 2);
    do_write(0, 8'h55);
    do_write(1, 8'h55);
    do_read(0, "R1 hi after write");
    do_read(1, "R1 lo after write");

    // R2 coherent snapshot
    @(negedge clk); c = m_cnt;
    reg_addr = ADDR_W'(0); reg_rd = 1'b1; #1;
    check("R2 hi byte", int'(reg_rdata), c >> 8);
    @(negedge clk); reg_rd = 1'b0;
    idle(10);
    do_read(1, "R2 snap lo"); check("R2 snap lo literal", last_rd, c & 255);
    do_read(1, "R2 live after snap");

    // R3 / R4 capture: ch0 rising, ch1 both
    do_write(10, 8'h0D);
    do_write(12, 8'h1F);
    @(negedge clk); c = m_cnt; cap_in[0] = 1'b1;
    idle(5);
    do_read(12, "R4 flags"); check("R4 cap0 flag", last_rd & 1, 1);
    do_read(2, "R3 cap0 hi"); v = last_rd << 8;
    do_read(3, "R3 cap0 lo"); v |= last_rd;
    check("R3 cap0 value", v, (c + 2) & 65535);
    do_write(12, 8'h1F);
    @(negedge clk); cap_in[0] = 1'b0;
    idle(5);
    do_read(12, "R3 fall ignored"); check("R3 falling not selected", last_rd & 1, 0);
    @(negedge clk); cap_in[1] = 1'b1;
    idle(5);
    @(negedge clk); c = m_cnt; cap_in[1] = 1'b0;
    idle(5);
    do_read(12, "R4 flags ch1"); check("R4 cap1 flag", (last_rd >> 1) & 1, 1);
    do_read(4, "R3 cap1 hi"); v = last_rd << 8;
    do_read(5, "R3 cap1 lo"); v |= last_rd;
    check("R3 cap1 falling value", v, (c + 2) & 65535);

    // R11 mask then enable
    check("R11 masked irq", int'(irq), 0);
    do_write(13, 8'h1F);
    check("R11 enabled irq", int'(irq), 1);

    // R5 freeze capture channel 0
    do_read(2, "R5 freeze hi");
    do_write(12, 8'h1F);
    @(negedge clk); cap_in[0] = 1'b1;
    idle(5);
    do_read(12, "R5 flags frozen"); check("R5 no flag while frozen", last_rd & 1, 0);
    do_read(3, "R5 old value kept");
    @(negedge clk); cap_in[0] = 1'b0;
    idle(5);
    @(negedge clk); c = m_cnt; cap_in[0] = 1'b1;
    idle(5);
    do_read(2, "R5 resumed hi"); v = last_rd << 8;
    do_read(3, "R5 resumed lo"); v |= last_rd;
    check("R5 capture resumes", v, (c + 2) & 65535);

    // R6 / R7 compare actions: ch0 toggle, ch1 set
    do_write(11, 8'h0D);
    t0 = (m_cnt + 60) & 65535; t1 = (m_cnt + 80) & 65535;
    do_write(6, t0 >> 8); do_write(7, t0 & 255);
    do_write(8, t1 >> 8); do_write(9, t1 & 255);
    do_write(12, 8'h1F);
    idle(100);
    check("R7 toggle and set", int'(cmp_out), 3);
    do_read(12, "R6 flags"); check("R6 both compare flags", (last_rd >> 2) & 3, 3);
    do_write(11, 8'h06);
    t0 = (m_cnt + 60) & 65535; t1 = (m_cnt + 80) & 65535;
    do_write(6, t0 >> 8); do_write(7, t0 & 255);
    do_write(8, t1 >> 8); do_write(9, t1 & 255);
    idle(100);
    check("R7 clear and toggle", int'(cmp_out), 0);
    do_write(11, 8'h00);
    do_write(12, 8'h1F);
    t0 = (m_cnt + 60) & 65535;
    do_write(6, t0 >> 8); do_write(7, t0 & 255);
    idle(80);
    do_read(12, "R6 no action"); check("R6 flag with no action", (last_rd >> 2) & 1, 1);
    check("R6 pin unchanged", int'(cmp_out), 0);

    // R8 compare frozen by high-byte write
    do_write(11, 8'h01);
    t0 = (m_cnt + 200) & 65535;
    do_write(6, t0 >> 8); do_write(7, t0 & 255);
    do_write(12, 8'h1F);
    do_write(6, t0 >> 8);
    idle(400);
    do_read(12, "R8 flags frozen"); check("R8 no match while frozen", (last_rd >> 2) & 1, 0);
    check("R8 pin held", int'(cmp_out[0]), 0);
    t0 = (m_cnt + 50) & 65535;
    do_write(6, t0 >> 8);
    do_write(7, t0 & 255);
    idle(70);
    check("R8 match after release", int'(cmp_out[0]), 1);

    // R10 set wins over clear in the same cycle
    t0 = (m_cnt + 100) & 65535;
    do_write(6, t0 >> 8); do_write(7, t0 & 255);
    while (m_cnt != ((t0 - 1) & 65535)) @(negedge clk);
    do_write(12, 8'h04);
    do_read(12, "R10 flags"); check("R10 set wins", (last_rd >> 2) & 1, 1);
    do_write(12, 8'h04);
    do_read(12, "R10 cleared"); check("R10 clear by one", (last_rd >> 2) & 1, 0);

    // R9 overflow
    do_write(12, 8'h1F);
    while (m_cnt != 65534) @(negedge clk);
    idle(4);
    do_read(12, "R9 flags"); check("R9 overflow flag", (last_rd >> 4) & 1, 1);
    do_write(13, 8'h00);
    check("R11 irq off when disabled", int'(irq), 0);

    idle(4);
    summary();
    $finish;
  end
endmodule